// File: doc/BRIEF.md
# Reserved Load and Conditional Store Unit

This unit executes the two atomic word operations of a small 32-bit core: a load that reserves a memory word and a store that writes only if that reservation still holds. The core hands over a decoded request made of the instruction word, the base register value and the store data. The unit works out the effective address and runs the access on a word-wide request/acknowledge memory port. It returns the loaded word and a pass/fail flag, and a fault pulse if the bus reports an error.

The unit holds one reservation: an address, a valid bit and the word that was loaded. A conditional store passes only if its address equals the reserved address and the word in memory still equals the recorded word. Any finished conditional store drops the reservation, whether it passed or failed. So does a bus error, and so does the kill input, which the core raises on trap entry, trap return and translation faults. An invalid reservation is held as an all-ones address backed by a cleared valid bit.

Top module: `lrsc_unit`

## Requirements
- R1: The opcode sits in instruction bits 31:26. 0x1b selects the reserving load and 0x33 the conditional store. Any other opcode causes no memory access, no done pulse and no busy.
- R2: The reserving load reads the word at base plus the sign-extended bits 15:0. It returns that word on rdata_o with a one-cycle done_o, and records the address and word as a valid reservation.
- R3: The conditional store address is base plus the sign-extended 16-bit value {bits 25:21, bits 10:0}. If the reservation is invalid or its address differs, the store completes one cycle after acceptance with flag 0 and makes no memory access.
- R4: On an address match the unit reads the reserved word. If that word equals the recorded word, it writes the store data and sets the flag to 1. If not, it skips the write and sets the flag to 0.
- R5: Every completed conditional store leaves the reservation invalid, whether it passed or failed.
- R6: A high resv_kill_i invalidates the reservation. If it is high in the same cycle as a reserving-load completion, the reservation stays invalid.
- R7: After reset the reservation is invalid and flag_o is 0. A conditional store to 0xFFFFFFFC then fails without touching memory.
- R8: A bus error in any phase ends the operation with done_o and fault_o high together. Memory stays unchanged, the reservation becomes invalid, and a conditional store reports flag 0.
- R9: mem_req_o stays high, with address, write enable and write data stable, until mem_ack_i. busy_o is high while an access is outstanding, and requests offered while busy are ignored.
- R10: flag_o holds the result of the last completed conditional store. Reserving loads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request offered (taken only while not busy) |
| req_insn_i | input | 32 | Instruction word: opcode and immediates |
| req_base_i | input | 32 | Base register value |
| req_wdata_i | input | 32 | Store data for the conditional store |
| resv_kill_i | input | 1 | Invalidate the reservation (trap, trap return, fault) |
| busy_o | output | 1 | Memory access outstanding; core must stall |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Word returned by the reserving load |
| flag_o | output | 1 | Conditional-store result flag |
| fault_o | output | 1 | Bus error pulse, high together with done_o |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| mem_err_i | input | 1 | Bus error, valid with acknowledge |

## Verification
The assertions check on every cycle that a memory request stays stable until it is acknowledged, that a fault comes only with done, and that done never coincides with busy. They also check that the write phase starts only after a read whose word matched the recorded value, and that any clear leaves the reservation invalid with the all-ones address. Other behaviours need the bench's scenarios. These are the memory-level outcome of each operation sequence, with other writers changing memory between the reserving load and the store, and the kill landing exactly on a load's completion. They also include the reset-state store to 0xFFFFFFFC, requests offered while busy, and bus errors in each phase.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    localparam int unsigned ILEN     = 32;
    localparam int unsigned OPC_MSB  = 31;
    localparam int unsigned OPC_LSB  = 26;
    localparam int unsigned OPC_W    = OPC_MSB - OPC_LSB + 1;
    localparam logic [OPC_W-1:0] OPC_RESV_LOAD = 6'h1b;
    localparam logic [OPC_W-1:0] OPC_COND_STORE = 6'h33;
    localparam int unsigned IMM_W    = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LR_RD = 2'd1,
        ST_SC_RD = 2'd2,
        ST_SC_WR = 2'd3
    } lrsc_state_e;
endpackage

// File: rtl/lrsc_agen.sv
module lrsc_agen
    import lrsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] insn_i,
    input  logic [XLEN-1:0] base_i,
    output logic            is_lr_o,
    output logic            is_sc_o,
    output logic [XLEN-1:0] ea_o
);
    logic [OPC_W-1:0] opc;
    logic [IMM_W-1:0] imm_ld;
    logic [IMM_W-1:0] imm_st;
    logic [XLEN-1:0]  off_ld;
    logic [XLEN-1:0]  off_st;

    always_comb begin
        opc     = insn_i[OPC_MSB:OPC_LSB];
        is_lr_o = (opc == OPC_RESV_LOAD);
        is_sc_o = (opc == OPC_COND_STORE);
        imm_ld  = insn_i[15:0];
        imm_st  = {insn_i[25:21], insn_i[10:0]};
        off_ld  = {{(XLEN-IMM_W){imm_ld[IMM_W-1]}}, imm_ld};
        off_st  = {{(XLEN-IMM_W){imm_st[IMM_W-1]}}, imm_st};
        ea_o    = base_i + (is_sc_o ? off_st : off_ld);
    end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_i,
    input  logic [XLEN-1:0] set_addr_i,
    input  logic [XLEN-1:0] set_val_i,
    input  logic            clr_i,
    input  logic [XLEN-1:0] probe_addr_i,
    output logic            hit_o,
    output logic [XLEN-1:0] val_o
);
    localparam logic [XLEN-1:0] ADDR_NONE = '1;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] val;
    } resv_t;

    resv_t d, q;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.valid = 1'b0;
            d.addr  = ADDR_NONE;
        end else if (set_i) begin
            d.valid = 1'b1;
            d.addr  = set_addr_i;
            d.val   = set_val_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.valid <= 1'b0;
            q.addr  <= ADDR_NONE;
            q.val   <= '0;
        end else begin
            q <= d;
        end
    end

    assign hit_o = q.valid && (q.addr == probe_addr_i);
    assign val_o = q.val;

    // R6
    clr_leaves_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q.valid);

    // R7
    invalid_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.valid |-> (q.addr == ADDR_NONE));

    // R2
    set_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> (q.valid && q.addr == $past(set_addr_i) && q.val == $past(set_val_i)));
endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
    import lrsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic            is_lr_i,
    input  logic            is_sc_i,
    input  logic [XLEN-1:0] ea_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            resv_hit_i,
    input  logic [XLEN-1:0] resv_val_i,
    output logic            resv_set_o,
    output logic            resv_clr_o,
    output logic [XLEN-1:0] resv_set_addr_o,
    output logic [XLEN-1:0] resv_set_val_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] rdata_o,
    output logic            flag_o,
    output logic            fault_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    input  logic            mem_ack_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    input  logic            mem_err_i
);
    typedef struct packed {
        lrsc_state_e     state;
        logic [XLEN-1:0] addr;
        logic [XLEN-1:0] wdata;
        logic [XLEN-1:0] cmpval;
        logic [XLEN-1:0] rdata;
        logic            done;
        logic            fault;
        logic            flag;
    } ctrl_t;

    ctrl_t d, q;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.fault    = 1'b0;
        resv_set_o = 1'b0;
        resv_clr_o = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid_i && is_lr_i) begin
                    d.state = ST_LR_RD;
                    d.addr  = ea_i;
                end else if (req_valid_i && is_sc_i) begin
                    d.addr   = ea_i;
                    d.wdata  = wdata_i;
                    d.cmpval = resv_val_i;
                    if (resv_hit_i) begin
                        d.state = ST_SC_RD;
                    end else begin
                        d.done     = 1'b1;
                        d.flag     = 1'b0;
                        resv_clr_o = 1'b1;
                    end
                end
            end
            ST_LR_RD: begin
                if (mem_ack_i) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    if (mem_err_i) begin
                        d.fault    = 1'b1;
                        resv_clr_o = 1'b1;
                    end else begin
                        d.rdata    = mem_rdata_i;
                        resv_set_o = 1'b1;
                    end
                end
            end
            ST_SC_RD: begin
                if (mem_ack_i) begin
                    if (!mem_err_i && mem_rdata_i == q.cmpval) begin
                        d.state = ST_SC_WR;
                    end else begin
                        d.state    = ST_IDLE;
                        d.done     = 1'b1;
                        d.fault    = mem_err_i;
                        d.flag     = 1'b0;
                        resv_clr_o = 1'b1;
                    end
                end
            end
            ST_SC_WR: begin
                if (mem_ack_i) begin
                    d.state    = ST_IDLE;
                    d.done     = 1'b1;
                    d.fault    = mem_err_i;
                    d.flag     = !mem_err_i;
                    resv_clr_o = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, addr: '0, wdata: '0, cmpval: '0, rdata: '0,
                   done: 1'b0, fault: 1'b0, flag: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign resv_set_addr_o = q.addr;
    assign resv_set_val_o  = mem_rdata_i;
    assign busy_o          = (q.state != ST_IDLE);
    assign mem_req_o       = (q.state != ST_IDLE);
    assign mem_we_o        = (q.state == ST_SC_WR);
    assign mem_addr_o      = q.addr;
    assign mem_wdata_o     = q.wdata;
    assign done_o          = q.done;
    assign fault_o         = q.fault;
    assign flag_o          = q.flag;
    assign rdata_o         = q.rdata;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R8
    fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> done_o);

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R4
    write_after_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !$past(mem_we_o)) |-> ($past(mem_ack_i) && !$past(mem_err_i)
                                            && $past(mem_rdata_i) == $past(q.cmpval)));
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic [31:0]     req_insn_i,
    input  logic [XLEN-1:0] req_base_i,
    input  logic [XLEN-1:0] req_wdata_i,
    input  logic            resv_kill_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] rdata_o,
    output logic            flag_o,
    output logic            fault_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    input  logic            mem_ack_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    input  logic            mem_err_i
);
    logic            is_lr, is_sc;
    logic [XLEN-1:0] ea;
    logic            resv_hit;
    logic [XLEN-1:0] resv_val;
    logic            resv_set, ctrl_clr;
    logic [XLEN-1:0] resv_set_addr, resv_set_val;

    lrsc_agen #(.XLEN(XLEN)) u_agen (
        .insn_i  (req_insn_i),
        .base_i  (req_base_i),
        .is_lr_o (is_lr),
        .is_sc_o (is_sc),
        .ea_o    (ea)
    );

    lrsc_resv #(.XLEN(XLEN)) u_resv (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (resv_set),
        .set_addr_i   (resv_set_addr),
        .set_val_i    (resv_set_val),
        .clr_i        (ctrl_clr | resv_kill_i),
        .probe_addr_i (ea),
        .hit_o        (resv_hit),
        .val_o        (resv_val)
    );

    lrsc_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid_i),
        .is_lr_i         (is_lr),
        .is_sc_i         (is_sc),
        .ea_i            (ea),
        .wdata_i         (req_wdata_i),
        .resv_hit_i      (resv_hit),
        .resv_val_i      (resv_val),
        .resv_set_o      (resv_set),
        .resv_clr_o      (ctrl_clr),
        .resv_set_addr_o (resv_set_addr),
        .resv_set_val_o  (resv_set_val),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .rdata_o         (rdata_o),
        .flag_o          (flag_o),
        .fault_o         (fault_o),
        .mem_req_o       (mem_req_o),
        .mem_we_o        (mem_we_o),
        .mem_addr_o      (mem_addr_o),
        .mem_wdata_o     (mem_wdata_o),
        .mem_ack_i       (mem_ack_i),
        .mem_rdata_i     (mem_rdata_i),
        .mem_err_i       (mem_err_i)
    );
endmodule

// File: tb/lrsc_unit_tb.sv
module lrsc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_insn = '0;
    logic [31:0] req_base = '0;
    logic [31:0] req_wdata = '0;
    logic        resv_kill = 1'b0;
    logic        busy, done, flag, fault;
    logic [31:0] rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // memory responder state
    logic [31:0] mem [16];
    int          lat = 0;
    int          fixed_lat = -1;
    int          wait_cnt = 0;
    int          acc_cnt = 0;
    int          phase_idx = 0;
    int          err_phase = 0;

    // bench reference model
    logic [31:0] exp_mem [16];
    bit          m_valid = 1'b0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_val = '0;
    bit          m_flag = 1'b0;

    // captured results
    logic [31:0] got_rdata;
    bit          got_flag, got_fault, got_done;

    always #2 clk = ~clk;

    lrsc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_insn_i(req_insn),
        .req_base_i(req_base), .req_wdata_i(req_wdata), .resv_kill_i(resv_kill),
        .busy_o(busy), .done_o(done), .rdata_o(rdata), .flag_o(flag), .fault_o(fault),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .mem_err_i(mem_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int pick_lat();
        return (fixed_lat >= 0) ? fixed_lat : int'($urandom_range(0, 3));
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (mem_ack) begin
            mem_ack  = 1'b0;
            mem_err  = 1'b0;
            wait_cnt = 0;
        end else if (mem_req && rst_n) begin
            if (wait_cnt >= lat) begin
                mem_ack = 1'b1;
                acc_cnt++;
                phase_idx++;
                if (err_phase == phase_idx) begin
                    mem_err   = 1'b1;
                    mem_rdata = 32'hDEAD_0000;
                end else if (mem_we) begin
                    mem[mem_addr[5:2]] = mem_wdata;
                    mem_rdata = '0;
                end else begin
                    mem_rdata = mem[mem_addr[5:2]];
                end
                wait_cnt = 0;
                lat = pick_lat();
            end else begin
                wait_cnt++;
            end
        end
    end

    function automatic logic [31:0] insn_lr(input logic [15:0] imm);
        return {6'h1b, 5'd3, 5'd4, imm};
    endfunction

    function automatic logic [31:0] insn_sc(input logic [15:0] imm);
        return {6'h33, imm[15:11], 5'd4, 5'd5, imm[10:0]};
    endfunction

    function automatic logic [31:0] sext16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // drive one request and wait for completion (or confirm none when expect_none)
    task automatic issue(input logic [31:0] insn, input logic [31:0] base,
                         input logic [31:0] wd, input bit expect_none,
                         input bit kill_at_ack, input string req);
        int n;
        phase_idx = 0;
        lat = pick_lat();
        got_done = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_insn = insn; req_base = base; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (kill_at_ack) resv_kill = 1'b1;
        if (expect_none) begin
            for (int k = 0; k < 4; k++) begin
                chk(!done && !busy && !mem_req, req, "no activity on unknown opcode",
                    {29'd0, done, busy, mem_req}, 32'd0);
                @(negedge clk);
            end
            return;
        end
        n = 0;
        while (!done && n < 60) begin
            @(negedge clk);
            resv_kill = 1'b0;
            n++;
        end
        resv_kill = 1'b0;
        if (!done) chk(1'b0, req, "completion timeout", 32'd0, 32'd1);
        got_done  = done;
        got_rdata = rdata;
        got_flag  = flag;
        got_fault = fault;
    endtask

    task automatic do_lr(input int idx, input logic [15:0] imm, input int errp, input string req);
        logic [31:0] a;
        int acc0;
        a = {26'd0, idx[3:0], 2'b00};
        err_phase = errp;
        acc0 = acc_cnt;
        issue(insn_lr(imm), a - sext16(imm), 32'd0, 1'b0, 1'b0, req);
        chk(acc_cnt == acc0 + 1, req, "load access count", acc_cnt, acc0 + 1);
        chk(got_fault == (errp == 1), req, "load fault", {31'd0, got_fault}, {31'd0, errp == 1});
        if (errp == 1) begin
            m_valid = 1'b0;
        end else begin
            chk(got_rdata == exp_mem[idx], req, "load data", got_rdata, exp_mem[idx]);
            m_valid = 1'b1; m_addr = a; m_val = exp_mem[idx];
        end
        // R10: load leaves flag untouched
        chk(got_flag == m_flag, "R10", "flag after load", {31'd0, got_flag}, {31'd0, m_flag});
        err_phase = 0;
    endtask

    task automatic do_sc(input logic [31:0] a, input logic [15:0] imm, input logic [31:0] wd,
                         input int errp, input string req);
        int acc0, exp_acc;
        bit exp_flag, exp_fault;
        logic [3:0] idx;
        idx = a[5:2];
        err_phase = errp;
        acc0 = acc_cnt;
        exp_flag = 1'b0; exp_fault = 1'b0; exp_acc = 0;
        if (m_valid && m_addr == a) begin
            exp_acc = 1;
            if (errp == 1) exp_fault = 1'b1;
            else if (exp_mem[idx] == m_val) begin
                exp_acc = 2;
                if (errp == 2) exp_fault = 1'b1;
                else begin exp_flag = 1'b1; exp_mem[idx] = wd; end
            end
        end
        issue(insn_sc(imm), a - sext16(imm), wd, 1'b0, 1'b0, req);
        chk(got_flag == exp_flag, req, "store flag", {31'd0, got_flag}, {31'd0, exp_flag});
        chk(got_fault == exp_fault, req, "store fault", {31'd0, got_fault}, {31'd0, exp_fault});
        chk(acc_cnt == acc0 + exp_acc, req, "store access count", acc_cnt, acc0 + exp_acc);
        m_valid = 1'b0;
        m_flag = exp_flag;
        err_phase = 0;
    endtask

    task automatic cmp_mem(input string req);
        bit same;
        same = 1'b1;
        for (int i = 0; i < 16; i++) if (mem[i] !== exp_mem[i]) same = 1'b0;
        chk(same, req, "memory contents", {31'd0, same}, 32'd1);
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] imm;
        void'($urandom(32'h5A17));
        for (int i = 0; i < 16; i++) begin
            mem[i] = $urandom;
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(!busy && !done && !mem_req && !flag && !fault, "R7", "reset outputs",
            {27'd0, busy, done, mem_req, flag, fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: store to the all-ones-marker address fails, no access
        do_sc(32'hFFFF_FFFC, 16'h0000, 32'h1111_2222, 0, "R7");
        cmp_mem("R7");

        // R2 / R4 / R5: basic pass, then repeat fails
        do_lr(5, 16'h0010, 0, "R2");
        do_sc(32'h14, 16'hFFF0, 32'hCAFE_0001, 0, "R4");
        cmp_mem("R4");
        do_sc(32'h14, 16'h0000, 32'hCAFE_0002, 0, "R5");
        cmp_mem("R5");

        // R3: address mismatch, negative split immediate
        do_lr(2, 16'h8004, 0, "R2");
        do_sc(32'h0C, 16'hF804, 32'h0BAD_0BAD, 0, "R3");
        cmp_mem("R3");

        // R4: another writer changed the word
        do_lr(7, 16'h0000, 0, "R2");
        mem[7] = mem[7] ^ 32'h1; exp_mem[7] = mem[7];
        do_sc(32'h1C, 16'h0123, 32'h7777_7777, 0, "R4");
        cmp_mem("R4");

        // R6: kill while idle
        do_lr(9, 16'h0004, 0, "R2");
        @(negedge clk); resv_kill = 1'b1; @(negedge clk); resv_kill = 1'b0;
        m_valid = 1'b0;
        do_sc(32'h24, 16'h0000, 32'h6666_0000, 0, "R6");
        cmp_mem("R6");

        // R6: kill on the same cycle as load completion
        fixed_lat = 0;
        phase_idx = 0; err_phase = 0;
        issue(insn_lr(16'h0000), 32'h28, 32'd0, 1'b0, 1'b1, "R6");
        chk(got_rdata == exp_mem[10], "R6", "load data under kill", got_rdata, exp_mem[10]);
        m_valid = 1'b0;
        do_sc(32'h28, 16'h0000, 32'h6666_1111, 0, "R6");
        cmp_mem("R6");
        fixed_lat = -1;

        // R8: bus errors in each phase
        do_lr(3, 16'h0000, 1, "R8");
        do_sc(32'h0C, 16'h0000, 32'h8888_0000, 0, "R8");
        do_lr(4, 16'h0002, 0, "R2");
        do_sc(32'h10, 16'h0000, 32'h8888_1111, 1, "R8");
        do_lr(4, 16'h0000, 0, "R2");
        do_sc(32'h10, 16'h0000, 32'h8888_2222, 2, "R8");
        cmp_mem("R8");

        // R1: unknown opcode ignored
        begin
            int acc0;
            acc0 = acc_cnt;
            issue({6'h1c, 26'h0}, 32'h0, 32'h0, 1'b1, 1'b0, "R1");
            chk(acc_cnt == acc0, "R1", "no access on unknown opcode", acc_cnt, acc0);
        end

        // R9: request offered while busy is ignored
        begin
            int acc0;
            fixed_lat = 3;
            acc0 = acc_cnt;
            phase_idx = 0; lat = 3;
            @(negedge clk);
            req_valid = 1'b1; req_insn = insn_lr(16'h0000); req_base = 32'h00;
            @(negedge clk);
            req_insn = insn_lr(16'h0004);
            chk(busy && mem_req, "R9", "busy during access", {30'd0, busy, mem_req}, 32'd3);
            @(negedge clk);
            req_valid = 1'b0;
            while (!done) @(negedge clk);
            chk(rdata == exp_mem[0], "R9", "first request result", rdata, exp_mem[0]);
            repeat (6) @(negedge clk);
            chk(acc_cnt == acc0 + 1 && !busy, "R9", "busy request ignored", acc_cnt, acc0 + 1);
            m_valid = 1'b1; m_addr = 32'h0; m_val = exp_mem[0];
            fixed_lat = -1;
        end

        // random mix
        for (int it = 0; it < 400; it++) begin
            int sel, idx, errp;
            sel = $urandom_range(0, 99);
            idx = $urandom_range(0, 15);
            imm = 16'($urandom_range(0, 65535));
            errp = ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 2)) : 0;
            if (sel < 40) begin
                do_lr(idx, imm, (errp == 1) ? 1 : 0, "R2");
            end else if (sel < 80) begin
                logic [31:0] a;
                a = (m_valid && $urandom_range(0, 3) != 0) ? m_addr : {26'd0, idx[3:0], 2'b00};
                do_sc(a, imm, $urandom, errp, "R4");
            end else if (sel < 90) begin
                if ($urandom_range(0, 1) == 1) mem[idx] = $urandom;
                exp_mem[idx] = mem[idx];
            end else if (sel < 95) begin
                @(negedge clk); resv_kill = 1'b1; @(negedge clk); resv_kill = 1'b0;
                m_valid = 1'b0;
            end else begin
                int acc0;
                logic [5:0] op;
                op = 6'($urandom_range(0, 63));
                if (op == 6'h1b || op == 6'h33) op = 6'h00;
                acc0 = acc_cnt;
                issue({op, 26'($urandom)}, $urandom, $urandom, 1'b1, 1'b0, "R1");
                chk(acc_cnt == acc0, "R1", "no access on unknown opcode", acc_cnt, acc0);
            end
            cmp_mem("R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule